// File: doc/BRIEF.md
# Dual-Mode Serial Character Transmitter

This block turns one parallel character at a time into a bit stream on a single output line. Asynchronous mode builds a character frame: a low start bit, then 5 to 9 data bits with the least significant bit first, then an optional parity bit (even or odd), then one or two high stop bits. Master SPI mode sends exactly eight data bits, with the most or the least significant bit first. It drives a generated serial clock next to the data and adds no framing bits. Both modes share one shift register and one output pin.

A producer offers words through a ready/valid handshake. The configuration inputs (mode, width, parity, stop count, bit order, baud divisor) are sampled once, when a word is accepted, so they may change while a frame is on the line. A word can be accepted in the final clock of the frame in flight, so consecutive characters leave with no idle gap. When the enable input is low, the line is forced high and any frame in progress is dropped.

Top module: `frame_serializer`

## Requirements
- R1: Out of reset and whenever no frame is in progress, `tx_line` is 1, `busy` is 0 and `spi_clk` is 0.
- R2: In asynchronous mode (`cfg_mode`=0) the line carries a 0 start bit and then `cfg_width` data bits (legal 5..9), bit 0 first. Each bit lasts `cfg_div` clocks. Data bits above the width have no effect.
- R3: With `cfg_par_en`=1 a parity bit follows the last data bit. For even parity (`cfg_par_odd`=0) it is 1 when the data bits hold an odd number of ones. For odd parity (`cfg_par_odd`=1) it is 1 when they hold an even number of ones.
- R4: The frame closes with one high stop bit, or two when `cfg_two_stop`=1.
- R5: In SPI mode (`cfg_mode`=1) exactly 8 bits of `in_data[7:0]` are sent with no start, parity or stop bits. The order is bit 7 first when `cfg_msb_first`=1 and bit 0 first otherwise. Each bit lasts 2×`cfg_div` clocks, with `spi_clk` low for the first half and high for the second half, so data changes only on its falling edge.
- R6: `in_ready` is high only when `en` is 1 and the block is idle or in the last clock of a frame. A word taken with `in_valid`&`in_ready` puts its first bit on the line in the next clock, with no gap after a previous frame.
- R7: The configuration is captured when a word is accepted. Changing it during a frame affects only later frames.
- R8: While `en` is 0 no word is accepted and `tx_line` is 1. Dropping `en` mid-frame returns the block to idle.
- R9: After the last bit of a frame, with no word pending, the line returns to idle high and `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Block enable |
| cfg_mode | input | 1 | 0 asynchronous framing, 1 master SPI |
| cfg_width | input | 4 | Asynchronous data bit count, 5..9 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even parity |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_msb_first | input | 1 | SPI order: 1 bit 7 first, 0 bit 0 first |
| cfg_div | input | DIV_W (16) | Clocks per bit (asynchronous) or per clock half (SPI) |
| in_data | input | 9 | Character to send |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Character can be taken this cycle |
| tx_line | output | 1 | Serial data line |
| spi_clk | output | 1 | Generated serial clock in SPI mode |
| busy | output | 1 | Frame in progress |

## Verification
The end of one frame and the acceptance of the next word can fall in the same clock. The same edge that finishes the last stop bit (or the last SPI bit) must reload the shift register instead of returning to idle. The bench provokes this by keeping `in_valid` high with a second word while a frame is on the line, and it changes the width in the same stroke. It then checks that `in_ready` is high exactly in the last clock of the first frame. It also checks that the start bit (or the first SPI bit) of the second frame appears in the very next clock, and that the first frame kept its own width while the second used the new one.

// File: rtl/sfx_pkg.sv
// Shared constants and types for the dual-mode serial transmitter.
// Assumes at most 9 asynchronous data bits, one parity bit and two stop bits.
package sfx_pkg;
    localparam int DATA_W  = 9;
    localparam int MIN_W   = 5;
    localparam int SPI_W   = 8;
    localparam int FRAME_W = 1 + DATA_W + 1 + 2;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    typedef enum logic {
        MODE_ASYNC = 1'b0,
        MODE_SPI   = 1'b1
    } mode_e;
endpackage

// File: rtl/sfx_baud.sv
// Bit-time tick generator: pulses tick every div clocks while run is high.
// Assumes restart is asserted on the edge where a new frame is loaded; div=0 acts as 1.
module sfx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    // Terminal count of the divider.
    always_comb lim = (div == '0) ? '0 : div - 1'b1;

    // One-clock pulse at the end of each period.
    always_comb tick = run && (cnt == lim);

    // Period counter, cleared on restart or while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) cnt <= '0;
        else if (cnt == lim)           cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sfx_framer.sv
// Combinational frame builder: lays out the bits of one character in send order
// (index 0 goes first) and reports the bit count. Unused upper positions are 1.
// Assumes width outside 5..9 is clamped to the nearest legal value.
module sfx_framer
    import sfx_pkg::*;
(
    input  mode_e                mode,
    input  logic [3:0]           width,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 two_stop,
    input  logic                 msb_first,
    input  logic [DATA_W-1:0]    data,
    output logic [FRAME_W-1:0]   bits,
    output logic [LEN_W-1:0]     len
);
    logic [3:0]         w_eff;
    logic [DATA_W-1:0]  mask;
    logic [FRAME_W-1:0] dext;
    logic               par_bit;

    // Clamp width, mask data and form the parity bit.
    always_comb begin
        w_eff = width;
        if (width < 4'(MIN_W))       w_eff = 4'(MIN_W);
        else if (width > 4'(DATA_W)) w_eff = 4'(DATA_W);
        for (int i = 0; i < DATA_W; i++) mask[i] = (i < int'(w_eff));
        par_bit = (^(data & mask)) ^ par_odd;
        dext    = FRAME_W'(data);
    end

    // Place start, data, parity and stop bits (or the SPI byte) in send order.
    always_comb begin
        bits = '1;
        if (mode == MODE_SPI) begin
            for (int i = 0; i < SPI_W; i++)
                bits[i] = msb_first ? data[SPI_W-1-i] : data[i];
            len = LEN_W'(SPI_W);
        end else begin
            for (int p = 0; p < FRAME_W; p++) begin
                if (p == 0)                                 bits[p] = 1'b0;
                else if (p <= int'(w_eff))                  bits[p] = dext[p-1];
                else if (p == int'(w_eff) + 1 && par_en)    bits[p] = par_bit;
            end
            len = LEN_W'(int'(w_eff) + 2 + int'(par_en) + int'(two_stop));
        end
    end
endmodule

// File: rtl/frame_serializer.sv
// Dual-mode serial transmitter: asynchronous character frames or master SPI bytes
// over one shift register and one output pin. Configuration is captured at word
// acceptance; a new word may be taken in the final clock of the current frame.
// Assumes a synchronous active-low reset and static-per-frame configuration.
module frame_serializer
    import sfx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cfg_mode,
    input  logic [3:0]        cfg_width,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              cfg_msb_first,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              tx_line,
    output logic              spi_clk,
    output logic              busy
);
    logic [FRAME_W-1:0] fr_bits;
    logic [LEN_W-1:0]   fr_len;
    logic [FRAME_W-1:0] shreg;
    logic [LEN_W-1:0]   left;
    logic               phase;
    mode_e              mode_q;
    logic [DIV_W-1:0]   div_q;
    logic               tick;
    logic               bit_end;
    logic               last;
    logic               take;

    sfx_framer u_framer (
        .mode      (mode_e'(cfg_mode)),
        .width     (cfg_width),
        .par_en    (cfg_par_en),
        .par_odd   (cfg_par_odd),
        .two_stop  (cfg_two_stop),
        .msb_first (cfg_msb_first),
        .data      (in_data),
        .bits      (fr_bits),
        .len       (fr_len)
    );

    sfx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .restart (take),
        .div     (div_q),
        .tick    (tick)
    );

    // End of a bit, end of the frame, and handshake.
    always_comb begin
        bit_end  = tick && (mode_q == MODE_ASYNC || phase);
        last     = busy && bit_end && (left == LEN_W'(1));
        in_ready = en && (!busy || last);
        take     = in_valid && in_ready;
    end

    // Frame sequencing: load, shift per bit, SPI half-period phase, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            shreg  <= '1;
            left   <= '0;
            phase  <= 1'b0;
            mode_q <= MODE_ASYNC;
            div_q  <= '0;
        end else if (!en) begin
            busy  <= 1'b0;
            phase <= 1'b0;
        end else if (take) begin
            busy   <= 1'b1;
            shreg  <= fr_bits;
            left   <= fr_len;
            phase  <= 1'b0;
            mode_q <= mode_e'(cfg_mode);
            div_q  <= cfg_div;
        end else if (busy && tick) begin
            if (mode_q == MODE_SPI && !phase) begin
                phase <= 1'b1;
            end else begin
                phase <= 1'b0;
                if (left == LEN_W'(1)) begin
                    busy <= 1'b0;
                end else begin
                    shreg <= {1'b1, shreg[FRAME_W-1:1]};
                    left  <= left - 1'b1;
                end
            end
        end
    end

    // Pin drive: idle high, forced high when disabled; clock high in second half.
    always_comb begin
        tx_line = (en && busy) ? shreg[0] : 1'b1;
        spi_clk = en && busy && (mode_q == MODE_SPI) && phase;
    end
endmodule

// File: rtl/sfx_checker.sv
// Property checker for frame_serializer, attached by bind below.
// Assumes the synchronous active-low reset of the checked block.
module sfx_checker (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic cfg_mode,
    input logic in_valid,
    input logic in_ready,
    input logic tx_line,
    input logic spi_clk,
    input logic busy
);
    // R1: idle line rests high.
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line);

    // R5: the generated clock stays low outside a frame.
    p_clk_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !spi_clk);

    // R2: an accepted asynchronous word starts with a low start bit.
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !cfg_mode) |=> !tx_line);

    // R6: an accepted word makes the block busy in the next clock.
    p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy);

    // R8: nothing is accepted while disabled.
    p_no_ready_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !in_ready);

    // R8: line held high while disabled.
    p_line_high_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> tx_line);
endmodule

bind frame_serializer sfx_checker i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .cfg_mode (cfg_mode),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .tx_line  (tx_line),
    .spi_clk  (spi_clk),
    .busy     (busy)
);

// File: tb/test_frame_serializer.sv
`timescale 1ns/1ps
module test_frame_serializer;
    localparam int D = 3;
    localparam int NV = 8;
    // Fields: [22] mode, [21:18] width, [17] par_en, [16] par_odd, [15] two_stop,
    // [14] msb_first, [13:5] data, [4:1] expected length, [0] expected parity bit.
    localparam logic [22:0] VEC [NV] = '{
        {1'b0, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 9'h055, 4'd10, 1'b0},
        {1'b0, 4'd8, 1'b1, 1'b0, 1'b0, 1'b0, 9'h0A7, 4'd11, 1'b1},
        {1'b0, 4'd8, 1'b1, 1'b1, 1'b1, 1'b0, 9'h0A7, 4'd12, 1'b0},
        {1'b0, 4'd5, 1'b1, 1'b0, 1'b0, 1'b0, 9'h1F3, 4'd8,  1'b1},
        {1'b0, 4'd9, 1'b1, 1'b1, 1'b1, 1'b0, 9'h100, 4'd13, 1'b0},
        {1'b0, 4'd7, 1'b1, 1'b0, 1'b1, 1'b0, 9'h000, 4'd11, 1'b0},
        {1'b1, 4'd8, 1'b0, 1'b0, 1'b0, 1'b1, 9'h0C5, 4'd8,  1'b0},
        {1'b1, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0C5, 4'd8,  1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
    logic cfg_mode = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic cfg_two_stop = 1'b0, cfg_msb_first = 1'b0;
    logic [3:0] cfg_width = 4'd8;
    logic [15:0] cfg_div = 16'(D);
    logic [8:0] in_data = '0;
    logic in_valid = 1'b0;
    logic in_ready, tx_line, spi_clk, busy;
    int errors = 0, checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    frame_serializer i_frame_serializer (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_mode(cfg_mode),
        .cfg_width(cfg_width), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_msb_first(cfg_msb_first),
        .cfg_div(cfg_div), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .tx_line(tx_line), .spi_clk(spi_clk), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected bit sequence from the requirements (index 0 is sent first).
    function automatic void build(input logic m, input int w, input logic pe,
                                  input logic par, input logic ts, input logic msb,
                                  input logic [8:0] d, output logic [12:0] e,
                                  output int n);
        e = '1;
        if (m) begin
            for (int i = 0; i < 8; i++) e[i] = msb ? d[7-i] : d[i];
            n = 8;
        end else begin
            e[0] = 1'b0;
            for (int i = 0; i < w; i++) e[1+i] = d[i];
            n = 1 + w;
            if (pe) begin e[n] = par; n++; end
            n = n + 1 + int'(ts);
        end
    endfunction

    // Observe a frame from the clock after acceptance; optionally offer the next word.
    task automatic watch(input logic [12:0] e, input int n, input bit spi,
                         input bit nv, input logic [8:0] nd, input int nw);
        int per;
        per = spi ? 2 * D : D;
        for (int c = 0; c < n * per; c++) begin
            @(negedge clk);
            if (c == 0) begin
                in_valid = nv;
                in_data  = nd;
                if (nw >= 0) cfg_width = 4'(nw);
            end
            if (c % per == D / 2) begin
                check(spi ? "R5 data bit" : "R2/R3/R4 frame bit", int'(tx_line), int'(e[c / per]));
                check("R6 busy in frame", int'(busy), 1);
                check("R5 clock low first half", int'(spi_clk), 0);
            end
            if (spi && (c % per == D + D / 2)) begin
                check("R5 clock high second half", int'(spi_clk), 1);
                check("R5 data stable", int'(tx_line), int'(e[c / per]));
            end
            if (c == n * per - 1) check("R6 ready in last clock", int'(in_ready), 1);
            else if (c % per != per - 1) check("R6 not ready mid frame", int'(in_ready), 0);
        end
    endtask

    task automatic check_idle(input string req);
        check(req, int'(tx_line), 1);
        check(req, int'(busy), 0);
        check(req, int'(spi_clk), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        if (!done) $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [12:0] e, e2;
        int n, n2;
        repeat (3) @(negedge clk);
        check_idle("R1 during reset");
        rst_n = 1'b1;
        en = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");
        check("R6 ready when idle", int'(in_ready), 1);

        // Table of vectors, one frame each.
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            cfg_mode = VEC[v][22]; cfg_width = VEC[v][21:18];
            cfg_par_en = VEC[v][17]; cfg_par_odd = VEC[v][16];
            cfg_two_stop = VEC[v][15]; cfg_msb_first = VEC[v][14];
            in_data = VEC[v][13:5]; in_valid = 1'b1;
            build(VEC[v][22], int'(VEC[v][21:18]), VEC[v][17], VEC[v][0],
                  VEC[v][15], VEC[v][14], VEC[v][13:5], e, n);
            check("R2/R4 frame length", n, int'(VEC[v][4:1]));
            @(posedge clk);
            watch(e, n, VEC[v][22], 1'b0, 9'h0, -1);
            @(negedge clk);
            check_idle("R9 idle after frame");
        end

        // R7/R6: back-to-back asynchronous words, width changed during the first.
        cfg_mode = 1'b0; cfg_width = 4'd8; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
        in_data = 9'h03C; in_valid = 1'b1;
        build(1'b0, 8, 1'b0, 1'b0, 1'b0, 1'b0, 9'h03C, e, n);
        build(1'b0, 6, 1'b0, 1'b0, 1'b0, 1'b0, 9'h081, e2, n2);
        @(posedge clk);
        watch(e, n, 1'b0, 1'b1, 9'h081, 6);
        watch(e2, n2, 1'b0, 1'b0, 9'h0, -1);
        @(negedge clk);
        check_idle("R9 idle after chain");

        // R5/R6: back-to-back SPI bytes, MSB first.
        cfg_mode = 1'b1; cfg_msb_first = 1'b1; in_data = 9'h0A5; in_valid = 1'b1;
        build(1'b1, 8, 1'b0, 1'b0, 1'b0, 1'b1, 9'h0A5, e, n);
        build(1'b1, 8, 1'b0, 1'b0, 1'b0, 1'b1, 9'h03C, e2, n2);
        @(posedge clk);
        watch(e, n, 1'b1, 1'b1, 9'h03C, -1);
        watch(e2, n2, 1'b1, 1'b0, 9'h0, -1);
        @(negedge clk);
        check_idle("R1 SPI idle after chain");

        // R8: disabled block ignores an offered word.
        cfg_mode = 1'b0;
        en = 1'b0; in_data = 9'h000; in_valid = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R8 not ready when off", int'(in_ready), 0);
            check("R8 line high when off", int'(tx_line), 1);
            check("R8 not busy when off", int'(busy), 0);
        end
        in_valid = 1'b0;
        en = 1'b1;
        @(negedge clk);
        check_idle("R8 idle after enable");

        // R8: drop enable in the middle of an all-zero frame.
        in_data = 9'h000; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (5) @(negedge clk);
        check("R8 line low mid frame", int'(tx_line), 0);
        en = 1'b0;
        @(negedge clk);
        check("R8 line forced high", int'(tx_line), 1);
        en = 1'b1;
        @(negedge clk);
        check_idle("R8 frame abandoned");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule